// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It produces the command, clock-enable, bank-address and address pins during the time between reset and normal operation. After reset it keeps clock enable low for a programmable settling time. It then raises clock enable with a no-operation and steps through the initialization commands in a fixed order. Each command is followed by the gap the memory requires before the next one: the precharge recovery time, the refresh cycle time, the mode-register spacing and the DLL lock time.

The commands run in this order. A precharge of all banks comes first. Next come an extended mode register write that turns the DLL on and a base mode register write that resets the DLL. A second precharge-all and a programmable number of auto-refresh commands follow. The sequence closes with a base mode register write that leaves the DLL-reset bit clear. The two mode values come in on input ports and the block sets or clears the DLL bits in them. Once the last mode-register gap has elapsed, `init_done` rises. The normal command path can then take over the pins.

All timing values are parameters counted in clock cycles. A command "issued at cycle t" means it is visible on the registered outputs in the cycle after clock edge t. A gap of G means the next command appears G edges later.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: After `rst_n` is released, `cke` stays low for STAB_CYC rising edges and rises on edge STAB_CYC. While `cke` is low the command is NOP. Once `cke` is high it stays high until reset.
- R2: The first command other than NOP is precharge-all. It appears one cycle after `cke` rises, encoded {cs_n,ras_n,cas_n,we_n}=0010, with address bit 10 high, all other address bits low and bank address 0.
- R3: TRP_CYC cycles after the first precharge, an extended mode register write appears. It is encoded 0000 with bank address 01 and the address equal to `emr_val` with bit 0 forced low (DLL enabled).
- R4: TMRD_CYC cycles later, a base mode register write appears. It is encoded 0000 with bank address 00 and the address equal to `mr_val` with bit 8 forced high (DLL reset).
- R5: TMRD_CYC cycles after the DLL-reset write, a second precharge-all appears, encoded as in R2.
- R6: NUM_REF auto-refresh commands follow, encoded 0001 with address and bank address 0. The first comes TRP_CYC cycles after the second precharge and each later one comes TRFC_CYC cycles after the previous.
- R7: The final base mode register write is encoded 0000 with bank address 00 and the address equal to `mr_val` with bit 8 forced low. It appears at the later of two points: TRFC_CYC cycles after the last refresh, or DLL_LOCK_CYC cycles after the DLL-reset write.
- R8: `init_done` rises TMRD_CYC cycles after the final mode register write and stays high until reset.
- R9: Every cycle after `cke` rises that carries none of the commands above drives NOP (0111). No command is issued after the final mode register write.
- R10: Asserting `rst_n` low at any point forces `cke` low, NOP, address 0 and `init_done` low. Releasing it restarts the whole sequence from the settling wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emr_val | input | ADDR_W | Extended mode value; bit 0 is forced low when written |
| mr_val | input | ADDR_W | Base mode value; bit 8 is set for the DLL-reset write and cleared for the final write |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address; selects the mode register for mode writes |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | High once initialization has completed |

## Verification
The hardest case to reach is the final mode register write. Two separate windows hold it back: the refresh spacing and the DLL lock count. Which one ends last depends only on the parameter mix. The bench therefore runs two instances side by side. In one, a long lock count outlasts the refreshes, so the sequencer must hold NOP after the refresh gap has already elapsed. In the other, a short lock count and three refreshes leave the refresh spacing as the limit. The bench also asserts reset just after the first precharge, while the sequence is running. It then checks that the full command list replays from the settling wait with the same spacing.

// File: rtl/ddr_pwrup_pkg.sv
package ddr_pwrup_pkg;

    // Operation requested by the sequencer for one cycle
    typedef enum logic [2:0] {
        OP_NOP,
        OP_PREA,
        OP_EMRS,
        OP_MRS_DLLRST,
        OP_REF,
        OP_MRS_FINAL
    } op_e;

    // Position in the initialization flow
    typedef enum logic [3:0] {
        SG_STAB,
        SG_CKE,
        SG_PREA1,
        SG_EMRS,
        SG_MRS_RST,
        SG_PREA2,
        SG_REF,
        SG_MRS_FIN,
        SG_DONE
    } stage_e;

    // Pin encodings {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] PIN_NOP  = 4'b0111;
    localparam logic [3:0] PIN_PREA = 4'b0010;
    localparam logic [3:0] PIN_MODE = 4'b0000;
    localparam logic [3:0] PIN_REF  = 4'b0001;

    // Address bits with a fixed meaning during initialization
    localparam int A_DLL_DIS = 0;
    localparam int A_DLL_RST = 8;
    localparam int A_ALLBANK = 10;

endpackage

// File: rtl/pu_down_cnt.sv
module pu_down_cnt #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= W'(RST_VAL);
        else
            cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R9: a running window shrinks by exactly one per cycle
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

    // R7: an expired window stays expired until reloaded
    p_zero_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/pu_seq_fsm.sv
module pu_seq_fsm
    import ddr_pwrup_pkg::*;
#(
    parameter int TRP_CYC  = 3,
    parameter int TRFC_CYC = 14,
    parameter int TMRD_CYC = 2,
    parameter int NUM_REF  = 2,
    parameter int GAP_W    = 16,
    parameter int REF_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gap_zero,
    input  logic             lock_zero,
    output op_e              op,
    output stage_e           stage_nx,
    output logic             gap_load,
    output logic [GAP_W-1:0] gap_val,
    output logic             lock_load
);

    localparam logic [GAP_W-1:0] GAP_ONE  = '0;
    localparam logic [GAP_W-1:0] GAP_TRP  = GAP_W'(TRP_CYC - 1);
    localparam logic [GAP_W-1:0] GAP_TRFC = GAP_W'(TRFC_CYC - 1);
    localparam logic [GAP_W-1:0] GAP_TMRD = GAP_W'(TMRD_CYC - 1);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(NUM_REF);

    typedef struct packed {
        stage_e           stage;
        logic [REF_W-1:0] ref_n;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        op        = OP_NOP;
        gap_load  = 1'b0;
        gap_val   = GAP_ONE;
        lock_load = 1'b0;
        if (gap_zero) begin
            unique case (s_q.stage)
                SG_STAB: begin
                    s_d.stage = SG_CKE;
                    gap_load  = 1'b1;
                    gap_val   = GAP_ONE;
                end
                SG_CKE: begin
                    s_d.stage = SG_PREA1;
                    op        = OP_PREA;
                    gap_load  = 1'b1;
                    gap_val   = GAP_TRP;
                end
                SG_PREA1: begin
                    s_d.stage = SG_EMRS;
                    op        = OP_EMRS;
                    gap_load  = 1'b1;
                    gap_val   = GAP_TMRD;
                end
                SG_EMRS: begin
                    s_d.stage = SG_MRS_RST;
                    op        = OP_MRS_DLLRST;
                    gap_load  = 1'b1;
                    gap_val   = GAP_TMRD;
                    lock_load = 1'b1;
                end
                SG_MRS_RST: begin
                    s_d.stage = SG_PREA2;
                    op        = OP_PREA;
                    gap_load  = 1'b1;
                    gap_val   = GAP_TRP;
                end
                SG_PREA2: begin
                    s_d.stage = SG_REF;
                    s_d.ref_n = REF_W'(1);
                    op        = OP_REF;
                    gap_load  = 1'b1;
                    gap_val   = GAP_TRFC;
                end
                SG_REF: begin
                    if (s_q.ref_n != REF_LAST) begin
                        s_d.ref_n = s_q.ref_n + REF_W'(1);
                        op        = OP_REF;
                        gap_load  = 1'b1;
                        gap_val   = GAP_TRFC;
                    end else if (lock_zero) begin
                        s_d.stage = SG_MRS_FIN;
                        op        = OP_MRS_FINAL;
                        gap_load  = 1'b1;
                        gap_val   = GAP_TMRD;
                    end
                end
                SG_MRS_FIN: begin
                    s_d.stage = SG_DONE;
                end
                SG_DONE: begin
                    s_d = s_q;
                end
                default: begin
                    s_d.stage = SG_STAB;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.stage <= SG_STAB;
            s_q.ref_n <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stage_nx = s_d.stage;

    // R9: no command leaves while a spacing window is still open
    p_hold_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !gap_zero |-> (op == OP_NOP));

    // R7: final mode write only after the lock window and every refresh
    p_final_after_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MRS_FINAL) |-> (lock_zero && s_q.ref_n == REF_LAST));

    // R6: refresh count never passes the programmed number
    p_ref_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_REF) |-> (s_q.stage == SG_PREA2 || s_q.ref_n < REF_LAST));

    // R8: completion is terminal
    p_done_terminal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stage == SG_DONE) |=> (s_q.stage == SG_DONE));

endmodule

// File: rtl/pu_pin_drive.sv
module pu_pin_drive
    import ddr_pwrup_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  stage_e            stage_nx,
    input  logic [ADDR_W-1:0] emr_val,
    input  logic [ADDR_W-1:0] mr_val,
    output logic              cke,
    output logic [3:0]        cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    localparam logic [BA_W-1:0] BA_BASE = '0;
    localparam logic [BA_W-1:0] BA_EXT  = BA_W'(1);

    typedef struct packed {
        logic              cke;
        logic [3:0]        cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } pins_t;

    pins_t p_d, p_q;

    always_comb begin
        p_d.cke  = (stage_nx != SG_STAB);
        p_d.done = (stage_nx == SG_DONE);
        p_d.cmd  = PIN_NOP;
        p_d.ba   = BA_BASE;
        p_d.addr = '0;
        unique case (op)
            OP_PREA: begin
                p_d.cmd            = PIN_PREA;
                p_d.addr[A_ALLBANK] = 1'b1;
            end
            OP_EMRS: begin
                p_d.cmd            = PIN_MODE;
                p_d.ba             = BA_EXT;
                p_d.addr           = emr_val;
                p_d.addr[A_DLL_DIS] = 1'b0;
            end
            OP_MRS_DLLRST: begin
                p_d.cmd            = PIN_MODE;
                p_d.addr           = mr_val;
                p_d.addr[A_DLL_RST] = 1'b1;
            end
            OP_MRS_FINAL: begin
                p_d.cmd            = PIN_MODE;
                p_d.addr           = mr_val;
                p_d.addr[A_DLL_RST] = 1'b0;
            end
            OP_REF: begin
                p_d.cmd = PIN_REF;
            end
            default: begin
                p_d.cmd = PIN_NOP;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.cke  <= 1'b0;
            p_q.cmd  <= PIN_NOP;
            p_q.ba   <= '0;
            p_q.addr <= '0;
            p_q.done <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign cke  = p_q.cke;
    assign cmd  = p_q.cmd;
    assign ba   = p_q.ba;
    assign addr = p_q.addr;
    assign done = p_q.done;

    // R1: clock enable never falls once raised
    p_cke_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // R1: only NOP while clock enable is low
    p_nop_cke_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd == PIN_NOP));

    // R8: completion flag is sticky and implies an enabled clock
    p_done_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    p_done_cke_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cke);

    // R9: nothing but NOP once initialization has completed
    p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd == PIN_NOP));

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
    import ddr_pwrup_pkg::*;
#(
    parameter int STAB_CYC     = 40000,
    parameter int TRP_CYC      = 3,
    parameter int TRFC_CYC     = 14,
    parameter int TMRD_CYC     = 2,
    parameter int DLL_LOCK_CYC = 200,
    parameter int NUM_REF      = 2,
    parameter int ADDR_W       = 13,
    parameter int BA_W         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] emr_val,
    input  logic [ADDR_W-1:0] mr_val,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int MAX_A   = (STAB_CYC > TRP_CYC) ? STAB_CYC : TRP_CYC;
    localparam int MAX_B   = (TRFC_CYC > TMRD_CYC) ? TRFC_CYC : TMRD_CYC;
    localparam int GAP_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam int LOCK_W  = $clog2(DLL_LOCK_CYC + 1);
    localparam int REF_W   = $clog2(NUM_REF + 1);
    localparam logic [LOCK_W-1:0] LOCK_LOAD = LOCK_W'(DLL_LOCK_CYC - 1);

    op_e              op;
    stage_e           stage_nx;
    logic             gap_load, gap_zero;
    logic [GAP_W-1:0] gap_val;
    logic             lock_load, lock_zero;
    logic [3:0]       cmd;

    pu_seq_fsm #(
        .TRP_CYC  (TRP_CYC),
        .TRFC_CYC (TRFC_CYC),
        .TMRD_CYC (TMRD_CYC),
        .NUM_REF  (NUM_REF),
        .GAP_W    (GAP_W),
        .REF_W    (REF_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gap_zero  (gap_zero),
        .lock_zero (lock_zero),
        .op        (op),
        .stage_nx  (stage_nx),
        .gap_load  (gap_load),
        .gap_val   (gap_val),
        .lock_load (lock_load)
    );

    pu_down_cnt #(
        .W       (GAP_W),
        .RST_VAL (STAB_CYC - 1)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    pu_down_cnt #(
        .W       (LOCK_W),
        .RST_VAL (0)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lock_load),
        .load_val (LOCK_LOAD),
        .zero     (lock_zero)
    );

    pu_pin_drive #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .stage_nx (stage_nx),
        .emr_val  (emr_val),
        .mr_val   (mr_val),
        .cke      (cke),
        .cmd      (cmd),
        .ba       (ba),
        .addr     (addr),
        .done     (init_done)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    // R4: the lock window is armed in the same cycle as the DLL-reset write
    p_lock_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MRS_DLLRST) |-> lock_load);

endmodule

// File: tb/sim_ddr_pwrup_seq.sv
module sim_ddr_pwrup_seq;

    localparam int AW = 13;
    // instance 0: DLL lock outlasts the refreshes
    localparam int S0 = 40, P0 = 3, F0 = 9,  M0 = 2, L0 = 60, N0 = 2;
    // instance 1: refresh spacing is the limit, three refreshes
    localparam int S1 = 20, P1 = 4, F1 = 11, M1 = 3, L1 = 8,  N1 = 3;

    localparam int W0  = L0 - (M0 + P0 + (N0 - 1) * F0);
    localparam int W1  = L1 - (M1 + P1 + (N1 - 1) * F1);
    localparam int FG0 = (F0 > W0) ? F0 : W0;
    localparam int FG1 = (F1 > W1) ? F1 : W1;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_MOD = 4'b0000;
    localparam logic [3:0] C_REF = 4'b0001;

    localparam logic [AW-1:0] EMR0 = 13'h0005, MR0 = 13'h0062;
    localparam logic [AW-1:0] EMR1 = 13'h0002, MR1 = 13'h0133;

    typedef struct packed {
        logic [3:0]    cmd;
        logic [1:0]    ba;
        logic [AW-1:0] addr;
        int            gap;
        int            req;
    } exp_t;

    localparam int NEV = 8;
    localparam int NEV_N [2] = '{7, 8};
    localparam int STAB [2] = '{S0, S1};
    localparam int TMRD [2] = '{M0, M1};

    localparam exp_t TAB [2][NEV] = '{
        '{  '{C_PRE, 2'd0, 13'h0400, 1,   2},   // R2 first precharge
            '{C_MOD, 2'd1, 13'h0004, P0,  3},   // R3 DLL enable, bit 0 cleared
            '{C_MOD, 2'd0, 13'h0162, M0,  4},   // R4 DLL reset, bit 8 set
            '{C_PRE, 2'd0, 13'h0400, M0,  5},   // R5 second precharge
            '{C_REF, 2'd0, 13'h0000, P0,  6},   // R6 refresh 1
            '{C_REF, 2'd0, 13'h0000, F0,  6},   // R6 refresh 2
            '{C_MOD, 2'd0, 13'h0062, FG0, 7},   // R7 lock-limited final write
            '{C_NOP, 2'd0, 13'h0000, 0,   9} },
        '{  '{C_PRE, 2'd0, 13'h0400, 1,   2},   // R2
            '{C_MOD, 2'd1, 13'h0002, P1,  3},   // R3
            '{C_MOD, 2'd0, 13'h0133, M1,  4},   // R4
            '{C_PRE, 2'd0, 13'h0400, M1,  5},   // R5
            '{C_REF, 2'd0, 13'h0000, P1,  6},   // R6
            '{C_REF, 2'd0, 13'h0000, F1,  6},   // R6
            '{C_REF, 2'd0, 13'h0000, F1,  6},   // R6 third refresh
            '{C_MOD, 2'd0, 13'h0033, FG1, 7} }  // R7 refresh-limited, bit 8 cleared
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          cke_a, cs_a, ras_a, cas_a, we_a, done_a;
    logic          cke_b, cs_b, ras_b, cas_b, we_b, done_b;
    logic [1:0]    ba_a, ba_b;
    logic [AW-1:0] addr_a, addr_b;

    ddr_pwrup_seq #(.STAB_CYC(S0), .TRP_CYC(P0), .TRFC_CYC(F0), .TMRD_CYC(M0),
                    .DLL_LOCK_CYC(L0), .NUM_REF(N0), .ADDR_W(AW), .BA_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .emr_val(EMR0), .mr_val(MR0),
        .cke(cke_a), .cs_n(cs_a), .ras_n(ras_a), .cas_n(cas_a), .we_n(we_a),
        .ba(ba_a), .addr(addr_a), .init_done(done_a));

    ddr_pwrup_seq #(.STAB_CYC(S1), .TRP_CYC(P1), .TRFC_CYC(F1), .TMRD_CYC(M1),
                    .DLL_LOCK_CYC(L1), .NUM_REF(N1), .ADDR_W(AW), .BA_W(2)) u1 (
        .clk(clk), .rst_n(rst_n), .emr_val(EMR1), .mr_val(MR1),
        .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b), .cas_n(cas_b), .we_n(we_b),
        .ba(ba_b), .addr(addr_b), .init_done(done_b));

    logic [3:0]    cmd_w  [2];
    logic          cke_w  [2];
    logic          done_w [2];
    logic [1:0]    ba_w   [2];
    logic [AW-1:0] addr_w [2];
    assign cmd_w[0]  = {cs_a, ras_a, cas_a, we_a};
    assign cmd_w[1]  = {cs_b, ras_b, cas_b, we_b};
    assign cke_w[0]  = cke_a;
    assign cke_w[1]  = cke_b;
    assign done_w[0] = done_a;
    assign done_w[1] = done_b;
    assign ba_w[0]   = ba_a;
    assign ba_w[1]   = ba_b;
    assign addr_w[0] = addr_a;
    assign addr_w[1] = addr_b;

    int            cyc [2], nlog [2], cke_rise [2], done_rise [2];
    int            bad_low [2], bad_drop [2];
    logic [3:0]    log_cmd  [2][12];
    logic [1:0]    log_ba   [2][12];
    logic [AW-1:0] log_addr [2][12];
    int            log_cyc  [2][12];

    // event monitor, sampled mid-cycle
    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                cyc[k] = 0; nlog[k] = 0; cke_rise[k] = -1; done_rise[k] = -1;
                bad_low[k] = 0; bad_drop[k] = 0;
            end else begin
                cyc[k]++;
                if (!cke_w[k] && cmd_w[k] != C_NOP) bad_low[k]++;
                if (cke_w[k] && cke_rise[k] < 0) cke_rise[k] = cyc[k];
                if (!cke_w[k] && cke_rise[k] >= 0) bad_drop[k]++;
                if (done_w[k] && done_rise[k] < 0) done_rise[k] = cyc[k];
                if (!done_w[k] && done_rise[k] >= 0) bad_drop[k]++;
                if (cmd_w[k] != C_NOP) begin
                    if (nlog[k] < 12) begin
                        log_cmd[k][nlog[k]]  = cmd_w[k];
                        log_ba[k][nlog[k]]   = ba_w[k];
                        log_addr[k][nlog[k]] = addr_w[k];
                        log_cyc[k][nlog[k]]  = cyc[k];
                    end
                    nlog[k]++;
                end
            end
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_reset_state(input string tag);
        for (int k = 0; k < 2; k++) begin
            chk(cke_w[k] == 1'b0, tag, $sformatf("u%0d cke in reset", k), int'(cke_w[k]), 0);
            chk(cmd_w[k] == C_NOP, tag, $sformatf("u%0d cmd in reset", k), int'(cmd_w[k]), int'(C_NOP));
            chk(done_w[k] == 1'b0, tag, $sformatf("u%0d init_done in reset", k), int'(done_w[k]), 0);
            chk(addr_w[k] == '0, tag, $sformatf("u%0d addr in reset", k), int'(addr_w[k]), 0);
        end
    endtask

    initial begin
        int wd;
        // reset state (R10)
        repeat (3) @(negedge clk);
        #1;
        chk_reset_state("R10");

        // first pass, interrupted shortly after the first precharge
        rst_n = 1'b1;
        repeat (S0 + 12) @(negedge clk);
        #1;
        chk(nlog[0] >= 1 && log_cyc[0][0] == S0 + 1, "R2", "u0 precharge before restart",
            log_cyc[0][0], S0 + 1);
        chk(cke_w[0] == 1'b1, "R1", "u0 cke high before restart", int'(cke_w[0]), 1);

        // asynchronous reset in the middle of the sequence (R10)
        rst_n = 1'b0;
        #1;
        chk_reset_state("R10");
        repeat (2) @(negedge clk);
        #1;
        rst_n = 1'b1;

        // run both instances to completion under a watchdog
        wd = 0;
        while (!(done_w[0] && done_w[1]) && wd < 5000) begin
            @(negedge clk);
            #1;
            wd++;
        end
        if (wd >= 5000) chk(1'b0, "R8", "watchdog: init_done never rose", 0, 1);
        repeat (30) @(negedge clk);
        #1;

        // table walk: command, bank, address and spacing for every step
        for (int k = 0; k < 2; k++) begin
            chk(cke_rise[k] == STAB[k], "R1", $sformatf("u%0d cke rise cycle", k),
                cke_rise[k], STAB[k]);
            chk(bad_low[k] == 0, "R1", $sformatf("u%0d commands while cke low", k), bad_low[k], 0);
            chk(nlog[k] == NEV_N[k], "R9", $sformatf("u%0d number of commands", k),
                nlog[k], NEV_N[k]);
            for (int i = 0; i < NEV_N[k]; i++) begin
                int prev;
                string r;
                prev = (i == 0) ? cke_rise[k] : log_cyc[k][i-1];
                r = $sformatf("R%0d", TAB[k][i].req);
                chk(log_cmd[k][i] == TAB[k][i].cmd, r, $sformatf("u%0d step %0d cmd", k, i),
                    int'(log_cmd[k][i]), int'(TAB[k][i].cmd));
                chk(log_ba[k][i] == TAB[k][i].ba, r, $sformatf("u%0d step %0d ba", k, i),
                    int'(log_ba[k][i]), int'(TAB[k][i].ba));
                chk(log_addr[k][i] == TAB[k][i].addr, r, $sformatf("u%0d step %0d addr", k, i),
                    int'(log_addr[k][i]), int'(TAB[k][i].addr));
                chk(log_cyc[k][i] - prev == TAB[k][i].gap, r, $sformatf("u%0d step %0d gap", k, i),
                    log_cyc[k][i] - prev, TAB[k][i].gap);
            end
            chk(done_rise[k] - log_cyc[k][NEV_N[k]-1] == TMRD[k], "R8",
                $sformatf("u%0d init_done delay", k),
                done_rise[k] - log_cyc[k][NEV_N[k]-1], TMRD[k]);
            chk(bad_drop[k] == 0, "R8", $sformatf("u%0d cke or init_done dropped", k), bad_drop[k], 0);
            chk(done_w[k] == 1'b1 && cmd_w[k] == C_NOP, "R9", $sformatf("u%0d idle NOP after done", k),
                int'(cmd_w[k]), int'(C_NOP));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule